// File: doc/BRIEF.md
# Reversible Biquinary Decade Counter

This block holds one decimal digit and counts it up or down on a single common clock. The digit is kept in two parts. A one-bit binary stage gives the odd/even half of the digit. A five-state one-hot quinary stage gives the digit pair. Every accepted count flips the binary stage. The quinary ring steps one place forward when a forward count arrives while the binary bit is 1. It steps one place backward when a backward count arrives while the binary bit is 0.

The forward and backward request inputs may come from slow or unsynchronized sources. Each request first passes through its own synchronizer chain. A rising-edge detector then turns it into a pulse exactly one clock wide. A combinational decoder builds ten one-hot digit lines, each the AND of one quinary line with one polarity of the binary bit. Registered carry-forward and borrow-backward outputs let several decades be chained.

Each clock cycle sorts the two request pulses into one of four named commands. CMD_HOLD means no request. CMD_FWD means forward only. CMD_BWD means backward only. CMD_CLASH means both requests in the same cycle; it is discarded and leaves the digit as it was. The quinary ring passes through its five states Q1 to Q5 along these transitions:

- Qk to Qk+1 on an advance.
- Q5 to Q1 on a wrapping advance.
- Qk to Qk-1 on a retreat.
- Q1 to Q5 on a wrapping retreat.
- Any pattern that is not one-hot goes to Q1 (repair).

Top module: `bq_decade_counter`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the counter goes to digit 0: `bin_bit`=0, `quin`=5'b00001, `digit`=10'b0000000001, and both carries are 0.
- R2: Encoding: `quin[k-1]` (k = 1..5) marks the digit pair 2(k-1) and 2(k-1)+1, and `bin_bit` is 0 for the even member and 1 for the odd member.
- R3: A request that stays high for any number of cycles produces exactly one count. A new count needs the request to go low and then high again.
- R4: Every accepted count, in either direction, inverts `bin_bit`.
- R5: A forward count with `bin_bit`=1 moves the active quinary line from bit k to bit k+1. From bit 4 it wraps to bit 0. With `bin_bit`=0 the ring does not move.
- R6: A backward count with `bin_bit`=0 moves the active quinary line from bit k to bit k-1. From bit 0 it wraps to bit 4. With `bin_bit`=1 the ring does not move.
- R7: A forward count from digit 9 gives digit 0 and raises `carry_fwd` for exactly one clock. No other count raises `carry_fwd`.
- R8: A backward count from digit 0 gives digit 9 and raises `carry_bwd` for exactly one clock. No other count raises `carry_bwd`.
- R9: If both request pulses fall in the same clock cycle, both are ignored. The digit stays unchanged and no carry is raised.
- R10: `digit[d]` is high exactly when the stored value is d, and only one digit line is high at a time.
- R11: Exactly one `quin` line is high at every clock edge after reset. Any other pattern is replaced by `quin[0]` on the next edge.
- R12: A request that rises just after a clock edge changes the outputs at the (SYNC_STAGES+1)-th rising edge that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous reset, active high |
| up_req | input | 1 | Forward count request, level, asynchronous |
| dn_req | input | 1 | Backward count request, level, asynchronous |
| bin_bit | output | 1 | Binary stage (odd/even of digit) |
| quin | output | QUIN_STATES | One-hot quinary stage |
| digit | output | 2*QUIN_STATES | One-hot decoded digit |
| carry_fwd | output | 1 | One-clock pulse on wrap 9 to 0 |
| carry_bwd | output | 1 | One-clock pulse on wrap 0 to 9 |

## Verification
The bench builds the counter with its defaults: SYNC_STAGES=2 and QUIN_STATES=5. These give a decade, so the outputs can be compared with a modulo-10 reference. With the two-flop synchronizer, the latency check looks for the change at exactly the third edge after a request rises. Full forward and backward sweeps cover both wraps of the ring and both carry pulses. A held request, coincident requests and a pseudo-random up/down sequence cover single counting, the clash rule and mixed direction changes.

// File: rtl/bq_pkg.sv
package bq_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_FWD   = 2'd1,
        CMD_BWD   = 2'd2,
        CMD_CLASH = 2'd3
    } bq_cmd_e;
endpackage

// File: rtl/bq_req_sync.sv
module bq_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic pulse
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], req_async};
            last_q <= chain[STAGES-1];
        end
    end

    assign pulse = chain[STAGES-1] & ~last_q;

    // R3: a synchronized request never yields two pulses in a row
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
endmodule

// File: rtl/bq_quinary_ring.sv
module bq_quinary_ring #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic         retreat,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= {{(N-1){1'b0}}, 1'b1};
        end else if (!$onehot(q)) begin
            q <= {{(N-1){1'b0}}, 1'b1};
        end else if (advance) begin
            q <= {q[N-2:0], q[N-1]};
        end else if (retreat) begin
            q <= {q[0], q[N-1:1]};
        end
    end

    // R11: one quinary line active at every edge after reset
    assert_ring_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $countones(q) == 1);
    // R5: advance from the top line wraps to the bottom line
    assert_ring_wrap_up_R5: assert property (@(posedge clk) disable iff (rst)
        (advance && !retreat && q[N-1]) |=> q[0]);
    // R6: retreat from the bottom line wraps to the top line
    assert_ring_wrap_dn_R6: assert property (@(posedge clk) disable iff (rst)
        (retreat && !advance && q[0]) |=> q[N-1]);
endmodule

// File: rtl/bq_digit_decode.sv
module bq_digit_decode #(
    parameter int N = 5
) (
    input  logic [N-1:0]   q,
    input  logic           lsb,
    output logic [2*N-1:0] dig
);
    for (genvar k = 0; k < N; k++) begin : g_pair
        assign dig[2*k]   = q[k] & ~lsb;
        assign dig[2*k+1] = q[k] &  lsb;
    end
endmodule

// File: rtl/bq_decade_counter.sv
module bq_decade_counter
    import bq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int QUIN_STATES = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     up_req,
    input  logic                     dn_req,
    output logic                     bin_bit,
    output logic [QUIN_STATES-1:0]   quin,
    output logic [2*QUIN_STATES-1:0] digit,
    output logic                     carry_fwd,
    output logic                     carry_bwd
);
    localparam int TOP = QUIN_STATES - 1;

    logic    fwd_p, bwd_p;
    logic    ring_adv, ring_ret;
    logic    cnt_en;
    bq_cmd_e cmd;

    bq_req_sync #(.STAGES(SYNC_STAGES)) u_sync_fwd (
        .clk(clk), .rst(rst), .req_async(up_req), .pulse(fwd_p));
    bq_req_sync #(.STAGES(SYNC_STAGES)) u_sync_bwd (
        .clk(clk), .rst(rst), .req_async(dn_req), .pulse(bwd_p));

    always_comb begin
        unique case ({fwd_p, bwd_p})
            2'b10:   cmd = CMD_FWD;
            2'b01:   cmd = CMD_BWD;
            2'b11:   cmd = CMD_CLASH;
            default: cmd = CMD_HOLD;
        endcase
    end

    always_comb begin
        ring_adv = 1'b0;
        ring_ret = 1'b0;
        cnt_en   = 1'b0;
        unique case (cmd)
            CMD_FWD: begin
                cnt_en   = 1'b1;
                ring_adv = bin_bit;
            end
            CMD_BWD: begin
                cnt_en   = 1'b1;
                ring_ret = ~bin_bit;
            end
            default: ;
        endcase
    end

    bq_quinary_ring #(.N(QUIN_STATES)) u_ring (
        .clk(clk), .rst(rst), .advance(ring_adv), .retreat(ring_ret), .q(quin));

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_bit   <= 1'b0;
            carry_fwd <= 1'b0;
            carry_bwd <= 1'b0;
        end else begin
            if (cnt_en) bin_bit <= ~bin_bit;
            carry_fwd <= (cmd == CMD_FWD) & bin_bit & quin[TOP];
            carry_bwd <= (cmd == CMD_BWD) & ~bin_bit & quin[0];
        end
    end

    bq_digit_decode #(.N(QUIN_STATES)) u_dec (
        .q(quin), .lsb(bin_bit), .dig(digit));

    // R4: each accepted count inverts the binary stage
    assert_bin_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_en |=> bin_bit != $past(bin_bit));
    // R9: coincident requests leave the state untouched
    assert_clash_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (fwd_p && bwd_p) |=> ($stable(bin_bit) && $stable(quin) && !carry_fwd && !carry_bwd));
    // R7: carry-forward appears only with the counter at zero
    assert_carry_fwd_R7: assert property (@(posedge clk) disable iff (rst)
        carry_fwd |-> (quin[0] && !bin_bit));
    // R8: borrow appears only with the counter at nine
    assert_carry_bwd_R8: assert property (@(posedge clk) disable iff (rst)
        carry_bwd |-> (quin[TOP] && bin_bit));
    // R10: exactly one digit line active
    assert_digit_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(digit) == 1);
endmodule

// File: tb/bq_decade_counter_tb_top.sv
module bq_decade_counter_tb_top;
    localparam int SYNC = 2;
    localparam int QN   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up_req = 1'b0;
    logic dn_req = 1'b0;
    logic bin_bit, carry_fwd, carry_bwd;
    logic [QN-1:0]   quin;
    logic [2*QN-1:0] digit;

    int n_chk = 0;
    int n_fail = 0;
    int ref_d = 0;
    int fwd_seen = 0;
    int bwd_seen = 0;
    int lcg = 12345;

    always #5 clk = ~clk;

    bq_decade_counter #(.SYNC_STAGES(SYNC), .QUIN_STATES(QN)) dut_i (
        .clk(clk), .rst(rst), .up_req(up_req), .dn_req(dn_req),
        .bin_bit(bin_bit), .quin(quin), .digit(digit),
        .carry_fwd(carry_fwd), .carry_bwd(carry_bwd));

    always @(negedge clk) begin
        if (!rst && carry_fwd) fwd_seen++;
        if (!rst && carry_bwd) bwd_seen++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        chk(bin_bit == 1'(ref_d % 2), {tag, " R2 bin"}, int'(bin_bit), ref_d % 2);
        chk(quin == QN'(1 << (ref_d / 2)), {tag, " R2/R11 quin"}, int'(quin), 1 << (ref_d / 2));
        chk(digit == (2*QN)'(1 << ref_d), {tag, " R10 digit"}, int'(digit), 1 << ref_d);
    endtask

    // one request pulse; kind 0=up 1=down 2=both
    task automatic do_count(input int kind, input string tag);
        int f0 = fwd_seen;
        int b0 = bwd_seen;
        int ef = 0;
        int eb = 0;
        @(negedge clk);
        up_req = (kind != 1);
        dn_req = (kind != 0);
        repeat (SYNC + 3) @(negedge clk);
        up_req = 1'b0;
        dn_req = 1'b0;
        repeat (3) @(negedge clk);
        if (kind == 0) begin
            if (ref_d == 9) ef = 1;
            ref_d = (ref_d + 1) % 10;
        end else if (kind == 1) begin
            if (ref_d == 0) eb = 1;
            ref_d = (ref_d + 9) % 10;
        end
        check_state(tag);
        chk(fwd_seen - f0 == ef, {tag, " R7 carry_fwd cycles"}, fwd_seen - f0, ef);
        chk(bwd_seen - b0 == eb, {tag, " R8 carry_bwd cycles"}, bwd_seen - b0, eb);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        ref_d = 0;
        check_state("R1 reset");
        chk(!carry_fwd && !carry_bwd, "R1 carries", int'({carry_fwd, carry_bwd}), 0);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1 after release");
    endtask

    task automatic t_latency_hold;
        up_req = 1'b1;
        repeat (SYNC) @(negedge clk);
        chk(digit == 10'd1, "R12 not yet changed", int'(digit), 1);
        @(negedge clk);
        chk(digit == 10'd2, "R12 changed on edge SYNC+1", int'(digit), 2);
        chk(bin_bit == 1'b1, "R4 toggle", int'(bin_bit), 1);
        repeat (20) @(negedge clk);
        chk(digit == 10'd2, "R3 held request counts once", int'(digit), 2);
        up_req = 1'b0;
        repeat (3) @(negedge clk);
        ref_d = 1;
    endtask

    task automatic t_fwd_sweep;
        for (int i = 0; i < 12; i++) do_count(0, "R5 fwd sweep");
    endtask

    task automatic t_bwd_sweep;
        for (int i = 0; i < 14; i++) do_count(1, "R6 bwd sweep");
    endtask

    task automatic t_clash;
        do_count(2, "R9 clash");
        while (ref_d != 9) do_count(0, "R9 setup");
        do_count(2, "R9 clash at nine");
        do_count(0, "R7 wrap to zero");
        do_count(2, "R9 clash at zero");
        do_count(1, "R8 wrap to nine");
    endtask

    task automatic t_random;
        for (int i = 0; i < 40; i++) begin
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            do_count((lcg >> 16) % 3, "R5/R6 random");
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_latency_hold();
        t_fwd_sweep();
        t_bwd_sweep();
        t_clash();
        t_random();
        rst = 1'b1;
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule